// File: doc/BRIEF.md
# Configurable External Interrupt Detector

This block turns external port-pin activity into interrupt requests for a small microcontroller. It has a parameterised number of channels, two by default. Each channel watches one pin of a parallel pin bus. A per-channel select field picks the pin. The block only samples that pin and never drives it, so whatever else uses the pin keeps working.

Each channel has two settings:
- A detection mode: edge or level.
- A polarity: active low or active high.

In edge mode, a qualifying edge sets a sticky pending flag. The flag stays set until the interrupt controller returns an acknowledge pulse for that channel. In level mode, the request simply mirrors the polarity-corrected pin level. A priority bit per channel is stored and presented to the interrupt controller.

The block has no data stream, so it has no valid/ready handshake. All pins are plain level signals:
- The register port writes on any clock edge where the write strobe is high.
- Read data is combinational from the address.
- Acknowledge is a one-cycle pulse per channel.

Top module: `ext_irq_unit`

## Requirements
- R1: After reset every register reads zero, which selects low-level mode on pin 0 with low priority for every channel. With all pins high, no request is raised.
- R2: In level mode (mode bit 0), the request of a channel equals its selected pin when polarity is 1, and the inverted pin when polarity is 0. A pin change reaches the request after two clock edges, and no state is retained.
- R3: In edge mode (mode bit 1) with polarity 0, a falling edge on the selected pin sets the channel request on the third clock edge after the pin changes.
- R4: In edge mode with polarity 1, a rising edge sets the request. An edge of the opposite direction does not.
- R5: An edge-mode request stays set after the pin returns. It clears on the clock edge that samples the channel's acknowledge bit high.
- R6: When a new qualifying edge is detected in the same cycle as the acknowledge, the request stays set.
- R7: Each channel responds only to the pin its select field names. Activity on all other pins has no effect on its request.
- R8: Rewriting a channel's select or polarity field never produces a request by itself, even when the old and new sources differ in active level.
- R9: The priority register at address 3 holds one bit per channel (bit i for channel i) and drives `irq_prio`. Its upper bits read zero and ignore writes.
- R10: The configuration register of channel i is at address i, with the pin select in bits 2:0 and the polarity in bit 4. The mode register is at address 2, with bit i for channel i. Every unused bit reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| port_pins | input | 8 | Monitored port pins, asynchronous |
| irq_ack | input | 2 | Per-channel acknowledge pulse |
| irq_req | output | 2 | Per-channel interrupt request |
| irq_prio | output | 2 | Per-channel priority, 1 = high |

## Verification
Three kinds of wrong internal state each have a distinct signature at the ports:
- A corrupted edge history shows as a request appearing three cycles after a configuration write, with no pin activity.
- A broken pending flag shows as a request that drops when the pin returns, or one that survives an acknowledge.
- A synchronizer with too few stages, or the wrong select decoding, moves the request by a cycle or onto the wrong pin.

The bench samples at the exact edge counts the requirements give, so a one-cycle slip is visible at once.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  typedef enum logic {
    DET_LEVEL = 1'b0,
    DET_EDGE  = 1'b1
  } det_mode_e;

  // Map a raw pin value onto "asserted" given the polarity bit (1 = high).
  function automatic logic active_of(input logic raw, input logic pol);
    return pol ? raw : ~raw;
  endfunction

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int PIN_W  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_W-1:0] pins_async,
  output logic [PIN_W-1:0] pins_sync
);

  logic [PIN_W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= pins_async;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign pins_sync = stage_q[STAGES-1];

endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs #(
  parameter int NCH    = 2,
  parameter int SEL_W  = 3,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  output logic [NCH*SEL_W-1:0]  sel_o,
  output logic [NCH-1:0]        pol_o,
  output logic [NCH-1:0]        mode_o,
  output logic [NCH-1:0]        prio_o,
  output logic [NCH-1:0]        cfg_load_o,
  output logic [SEL_W-1:0]      nxt_sel_o,
  output logic                  nxt_pol_o
);

  localparam int POL_BIT = SEL_W + 1;
  localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(NCH);
  localparam logic [ADDR_W-1:0] PRIO_A = ADDR_W'(NCH + 1);

  assign nxt_sel_o = reg_wdata[SEL_W-1:0];
  assign nxt_pol_o = reg_wdata[POL_BIT];

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_cfg
      assign cfg_load_o[c] = reg_we && (reg_addr == ADDR_W'(c));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sel_o[c*SEL_W +: SEL_W] <= '0;
          pol_o[c]                <= 1'b0;
        end else if (cfg_load_o[c]) begin
          sel_o[c*SEL_W +: SEL_W] <= nxt_sel_o;
          pol_o[c]                <= nxt_pol_o;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_o <= '0;
      prio_o <= '0;
    end else if (reg_we) begin
      if (reg_addr == MODE_A) mode_o <= reg_wdata[NCH-1:0];
      if (reg_addr == PRIO_A) prio_o <= reg_wdata[NCH-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int c = 0; c < NCH; c++) begin
      if (reg_addr == ADDR_W'(c)) begin
        reg_rdata[SEL_W-1:0] = sel_o[c*SEL_W +: SEL_W];
        reg_rdata[POL_BIT]   = pol_o[c];
      end
    end
    if (reg_addr == MODE_A) reg_rdata[NCH-1:0] = mode_o;
    if (reg_addr == PRIO_A) reg_rdata[NCH-1:0] = prio_o;
  end

  // R9: a priority write lands exactly the low channel bits
  p_prio_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == PRIO_A) |=> (prio_o == $past(reg_wdata[NCH-1:0])));

  // R10: mode bits only move on a mode-register write
  p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == MODE_A) |=> $stable(mode_o));

endmodule

// File: rtl/ext_irq_chan.sv
module ext_irq_chan
  import ext_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pin_sync,
  input  logic pol,
  input  logic mode,
  input  logic reseed,
  input  logic reseed_val,
  input  logic ack,
  output logic req
);

  logic act;
  logic prev_act_q;
  logic pending_q;
  logic edge_hit;
  det_mode_e det;

  assign det      = det_mode_e'(mode);
  assign act      = active_of(pin_sync, pol);
  assign edge_hit = (det == DET_EDGE) && act && !prev_act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_act_q <= 1'b0;
    else if (reseed) prev_act_q <= reseed_val;
    else prev_act_q <= act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending_q <= 1'b0;
    else if (det == DET_LEVEL) pending_q <= 1'b0;
    else if (edge_hit) pending_q <= 1'b1;
    else if (ack) pending_q <= 1'b0;
  end

  assign req = (det == DET_EDGE) ? pending_q : act;

  // R3: pending only rises after a detected edge
  p_set_needs_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending_q) |-> $past(edge_hit));

  // R5: acknowledge without a fresh edge clears the flag
  p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !edge_hit) |=> !pending_q);

  // R6: a fresh edge wins over a same-cycle acknowledge
  p_edge_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> pending_q);

  // R2: level mode keeps no sticky state
  p_level_nosticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (det == DET_LEVEL) |=> !pending_q);

  // R8: history taken from the new source on a configuration write
  p_reseed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reseed |=> (prev_act_q == $past(reseed_val)));

endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit
  import ext_irq_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int PIN_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_we,
  input  logic [$clog2(NCH+2)-1:0]    reg_addr,
  input  logic [DATA_W-1:0]           reg_wdata,
  output logic [DATA_W-1:0]           reg_rdata,
  input  logic [PIN_W-1:0]            port_pins,
  input  logic [NCH-1:0]              irq_ack,
  output logic [NCH-1:0]              irq_req,
  output logic [NCH-1:0]              irq_prio
);

  localparam int SEL_W  = $clog2(PIN_W);
  localparam int ADDR_W = $clog2(NCH + 2);

  logic [PIN_W-1:0]     pins_sync;
  logic [NCH*SEL_W-1:0] sel;
  logic [NCH-1:0]       pol;
  logic [NCH-1:0]       mode;
  logic [NCH-1:0]       cfg_load;
  logic [SEL_W-1:0]     nxt_sel;
  logic                 nxt_pol;

  ext_irq_sync #(.PIN_W(PIN_W), .STAGES(2)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .pins_async (port_pins),
    .pins_sync  (pins_sync)
  );

  ext_irq_regs #(
    .NCH(NCH), .SEL_W(SEL_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .sel_o      (sel),
    .pol_o      (pol),
    .mode_o     (mode),
    .prio_o     (irq_prio),
    .cfg_load_o (cfg_load),
    .nxt_sel_o  (nxt_sel),
    .nxt_pol_o  (nxt_pol)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [SEL_W-1:0] cur_sel;
      logic             pin_cur;
      logic             seed_val;
      logic             reseed;

      assign cur_sel  = sel[c*SEL_W +: SEL_W];
      assign pin_cur  = pins_sync[cur_sel];
      assign seed_val = active_of(pins_sync[nxt_sel], nxt_pol);
      assign reseed   = cfg_load[c] && ({nxt_pol, nxt_sel} != {pol[c], cur_sel});

      ext_irq_chan u_chan (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_sync   (pin_cur),
        .pol        (pol[c]),
        .mode       (mode[c]),
        .reseed     (reseed),
        .reseed_val (seed_val),
        .ack        (irq_ack[c]),
        .req        (irq_req[c])
      );
    end
  endgenerate

endmodule

// File: tb/ext_irq_unit_test.sv
module ext_irq_unit_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [7:0] port_pins = 8'hFF;
  logic [1:0] irq_ack = '0;
  logic [1:0] irq_req;
  logic [1:0] irq_prio;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ext_irq_unit uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .port_pins(port_pins),
    .irq_ack(irq_ack), .irq_req(irq_req), .irq_prio(irq_prio)
  );

  // {cfg0, cfg1, mode, pins_before, pins_after, expected_req}
  localparam logic [47:0] VEC [7] = '{
    {8'h00, 8'h11, 8'h00, 8'hFF, 8'hFE, 8'h03},  // level, both polarities
    {8'h00, 8'h11, 8'h00, 8'hFF, 8'hFD, 8'h00},
    {8'h02, 8'h13, 8'h03, 8'h04, 8'h08, 8'h03},  // falling on pin2, rising on pin3
    {8'h02, 8'h13, 8'h03, 8'h08, 8'h04, 8'h00},  // opposite edges ignored
    {8'h17, 8'h07, 8'h03, 8'h00, 8'h80, 8'h01},  // same pin, opposite polarity
    {8'h15, 8'h06, 8'h01, 8'h00, 8'h20, 8'h03},  // mixed edge and level
    {8'h14, 8'h04, 8'h03, 8'h00, 8'hEF, 8'h00}   // only other pins move
  };

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    cyc(1);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic ack_pulse();
    irq_ack = 2'b11;
    cyc(1);
    irq_ack = 2'b00;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] rv;
    cyc(2);
    rst_n = 1'b1;
    cyc(4);

    // R1 / R10: reset values
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), rv);
      chk("R1 reset readback", rv, 8'h00);
    end
    chk("R1 no request with pins high", {6'b0, irq_req}, 8'h00);
    chk("R1 low priority", {6'b0, irq_prio}, 8'h00);

    // R2: level latency, active low on pin 0
    port_pins = 8'hFE;
    cyc(1);
    chk("R2 level after one edge", {7'b0, irq_req[0]}, 8'h00);
    cyc(1);
    chk("R2 level after two edges", {7'b0, irq_req[0]}, 8'h01);
    port_pins = 8'hFF;
    cyc(2);
    chk("R2 level drops, no sticky", {7'b0, irq_req[0]}, 8'h00);

    // R3 / R5 / R6: falling edge on pin 0
    wr(2'd2, 8'h01);
    cyc(3); ack_pulse();
    port_pins = 8'hFE;
    cyc(2);
    chk("R3 not yet after two edges", {7'b0, irq_req[0]}, 8'h00);
    cyc(1);
    chk("R3 set on third edge", {7'b0, irq_req[0]}, 8'h01);
    port_pins = 8'hFF;
    cyc(3);
    chk("R5 sticky after pin returns", {7'b0, irq_req[0]}, 8'h01);
    port_pins = 8'hFE;
    cyc(2);
    irq_ack = 2'b01;
    cyc(1);
    irq_ack = 2'b00;
    chk("R6 edge beats same-cycle ack", {7'b0, irq_req[0]}, 8'h01);
    irq_ack = 2'b01;
    cyc(1);
    irq_ack = 2'b00;
    chk("R5 ack clears", {7'b0, irq_req[0]}, 8'h00);

    // R8: select change between sources of different level
    port_pins = 8'h02;
    wr(2'd0, 8'h10);
    cyc(3); ack_pulse(); cyc(1);
    chk("R8 baseline quiet", {7'b0, irq_req[0]}, 8'h00);
    wr(2'd0, 8'h11);
    cyc(4);
    chk("R8 no edge from select change", {7'b0, irq_req[0]}, 8'h00);
    port_pins = 8'h00;
    wr(2'd0, 8'h10);
    cyc(3); ack_pulse(); cyc(1);
    wr(2'd0, 8'h00);
    cyc(4);
    chk("R8 no edge from polarity flip", {7'b0, irq_req[0]}, 8'h00);

    // R9 / R10: register layout and unused bits
    wr(2'd3, 8'hFF);
    rd(2'd3, rv);
    chk("R9 priority upper bits zero", rv, 8'h03);
    cyc(1);
    chk("R9 priority output", {6'b0, irq_prio}, 8'h03);
    wr(2'd3, 8'h02);
    cyc(1);
    chk("R9 per-channel priority", {6'b0, irq_prio}, 8'h02);
    wr(2'd2, 8'hFF);
    rd(2'd2, rv);
    chk("R10 mode unused bits zero", rv, 8'h03);
    wr(2'd1, 8'hFF);
    rd(2'd1, rv);
    chk("R10 config fields", rv, 8'h17);

    // R7 with R2 R3 R4: vector table
    foreach (VEC[i]) begin
      port_pins = VEC[i][23:16];
      wr(2'd0, VEC[i][47:40]);
      wr(2'd1, VEC[i][39:32]);
      wr(2'd2, VEC[i][31:24]);
      cyc(3); ack_pulse(); cyc(1);
      port_pins = VEC[i][15:8];
      cyc(4);
      chk($sformatf("R7 (R2 R3 R4) vector %0d", i), {6'b0, irq_req}, VEC[i][7:0]);
    end

    finish_run();
  end

endmodule